// File: doc/BRIEF.md
# Loss-of-Signal Transition Monitor

This block raises an active-high loss-of-signal flag when the serial input chosen upstream stops toggling. It runs from the reference clock, which is nominally 14.14 MHz. The input comes from another clock domain, so the block first passes it through a chain of flip-flops. A change between two consecutive synchronised samples counts as a transition. The block does not try to tell noise from data, so every change counts as activity.

Time is measured in windows of `WIN_CYCLES` reference cycles. Each detected transition restarts the window timer and arms a one-window grace bit. The first window end after a transition uses up the grace. If the next window end arrives with still no transition, the flag rises. Any transition drops the flag on the following reference cycle. The result is deliberately asymmetric: the flag takes two full windows to assert, but releases within a few cycles.

With the default of 70 cycles, the flag asserts 140 reference cycles (about 9.9 us) after the last detected transition. Release takes `SYNC_STAGES`+1 cycles from a change at the pin.

Top module: `los_monitor`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `los` is 1 and the grace bit is clear. With no transition after reset, `los` stays 1.
- R2: After a detected transition, `los` rises exactly 2*`WIN_CYCLES` reference cycles after the cycle in which it was cleared, provided no further transition is detected. It is never high earlier in that interval.
- R3: A detected transition drives `los` to 0 on the next reference clock edge. Measured from a change at `sig_in` that is stable across edges, `los` reads 0 after `SYNC_STAGES`+1 rising edges and still reads 1 after `SYNC_STAGES` edges.
- R4: Both a rising and a falling change of `sig_in` count as a transition. A pulse that lasts one reference cycle therefore produces two transitions.
- R5: Once `los` is 1, it stays 1 for as long as no transition is detected, across any number of window ends.
- R6: Each detected transition restarts the window timer. Transitions spaced less than 2*`WIN_CYCLES` cycles apart keep `los` at 0 continuously.
- R7: `sig_in` is sampled through `SYNC_STAGES` flip-flops before it is compared. Only the synchronised samples feed the transition detector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock (nominally 14.14 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Selected serial input, asynchronous to clk_ref |
| los | output | 1 | Loss-of-signal flag, 1 = no transitions seen |

## Verification
The bench builds the block with `WIN_CYCLES` = 8 and `SYNC_STAGES` = 2. With these values the two-window assertion delay is only 16 cycles. This brings within reach, in a short run, many complete assert and release cycles, toggles spaced just inside and just outside the window, and single-cycle pulses. The exact rise cycle and the exact release latency are then compared every clock against a behavioural model that counts cycles since the last transition.

// File: rtl/los_pkg.sv
package los_pkg;

    typedef struct packed {
        logic armed;
        logic los;
    } los_hist_t;

    localparam los_hist_t LOS_HIST_RESET = '{armed: 1'b0, los: 1'b1};

endpackage

// File: rtl/los_sync.sv
module los_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.chain = {st_q.chain[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.chain[STAGES-1];
endmodule

// File: rtl/los_edge.sv
module los_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    output logic edge_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.prev = smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = smp ^ st_q.prev;
endmodule

// File: rtl/los_timer.sv
module los_timer #(
    parameter int WIN = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart || st_q.cnt == LAST) st_d.cnt = '0;
        else                             st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = (st_q.cnt == LAST);
endmodule

// File: rtl/los_history.sv
module los_history
    import los_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic tick_i,
    output logic los_o
);
    los_hist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_i) begin
            st_d.armed = 1'b1;
            st_d.los   = 1'b0;
        end else if (tick_i) begin
            if (st_q.armed) st_d.armed = 1'b0;
            else            st_d.los   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LOS_HIST_RESET;
        else        st_q <= st_d;
    end

    assign los_o = st_q.los;
endmodule

// File: rtl/los_monitor.sv
module los_monitor #(
    parameter int WIN_CYCLES  = 70,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic sig_in,
    output logic los
);
    logic sig_sync;
    logic det_edge;
    logic win_tick;

    los_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (sig_in),
        .q     (sig_sync)
    );

    los_edge u_edge (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .smp    (sig_sync),
        .edge_o (det_edge)
    );

    los_timer #(.WIN(WIN_CYCLES)) u_timer (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .restart (det_edge),
        .tick    (win_tick)
    );

    los_history u_hist (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .edge_i (det_edge),
        .tick_i (win_tick),
        .los_o  (los)
    );
endmodule

// File: rtl/los_monitor_checker.sv
module los_monitor_checker #(
    parameter int WIN_CYCLES = 70
) (
    input logic clk_ref,
    input logic rst_n,
    input logic det_edge,
    input logic win_tick,
    input logic los
);
    int unsigned gap;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)                   gap <= 0;
        else if (det_edge || win_tick) gap <= 0;
        else                          gap <= gap + 1;
    end

    // R3: a transition clears the flag next cycle
    a_r3_clear_after_edge: assert property (@(posedge clk_ref) disable iff (!rst_n)
        det_edge |=> !los);

    // R2: the flag can only rise at a window end
    a_r2_rise_on_tick: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(los) |-> $past(win_tick));

    // R5: quiet input keeps a raised flag raised
    a_r5_hold_high: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (los && !det_edge) |=> los);

    // R6: between window ends, a low flag stays low
    a_r6_low_between_ticks: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!los && !win_tick) |=> !los);

    // R6: window end comes exactly WIN_CYCLES after a restart
    a_r6_window_length: assert property (@(posedge clk_ref) disable iff (!rst_n)
        win_tick |-> (gap == WIN_CYCLES - 1));
endmodule

bind los_monitor los_monitor_checker #(.WIN_CYCLES(WIN_CYCLES)) u_los_chk (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .det_edge (det_edge),
    .win_tick (win_tick),
    .los      (los)
);

// File: tb/los_monitor_bench.sv
module los_monitor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 8;
    localparam int SYNC = 2;

    logic clk_ref = 1'b0;
    logic rst_n   = 1'b0;
    logic sig_in  = 1'b0;
    logic los;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    int cycles = 0;

    // behavioural reference model
    logic pipe [SYNC];
    logic prev_m;
    logic los_m;
    int   since;

    los_monitor #(.WIN_CYCLES(WIN), .SYNC_STAGES(SYNC)) u_los_monitor (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .sig_in  (sig_in),
        .los     (los)
    );

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: los actual=%b expected=%b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC; i++) pipe[i] = 1'b0;
            prev_m = 1'b0;
            los_m  = 1'b1;
            since  = 0;
        end else begin
            logic e;
            e = pipe[SYNC-1] ^ prev_m;
            prev_m = pipe[SYNC-1];
            for (int i = SYNC-1; i > 0; i--) pipe[i] = pipe[i-1];
            pipe[0] = sig_in;
            if (e) begin
                los_m = 1'b0;
                since = 0;
            end else begin
                since++;
                if (since == 2*WIN) los_m = 1'b1;
            end
        end
    end

    always @(negedge clk_ref) begin
        cycles++;
        if (rst_n) check(cur_req, los, los_m);
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_ref);
    endtask

    initial begin
        int lfsr;
        idle(3);
        check("R1", los, 1'b1);
        @(negedge clk_ref);
        rst_n = 1'b1;
        @(negedge clk_ref);
        check("R1", los, 1'b1);
        cur_req = "R5";
        idle(4*WIN);
        check("R5", los, 1'b1);

        // release latency through the synchroniser
        cur_req = "R3";
        sig_in = 1'b1;
        idle(SYNC);
        check("R7", los, 1'b1);
        @(negedge clk_ref);
        check("R3", los, 1'b0);

        // exact rise after quiet
        cur_req = "R2";
        idle(2*WIN - 2);
        check("R2", los, 1'b0);
        idle(2);
        check("R2", los, 1'b1);
        cur_req = "R5";
        idle(3*WIN);
        check("R5", los, 1'b1);

        // falling change and a single-cycle pulse
        cur_req = "R4";
        sig_in = 1'b0;
        idle(SYNC + 1);
        check("R4", los, 1'b0);
        idle(3*WIN);
        check("R4", los, 1'b1);
        sig_in = 1'b1;
        @(negedge clk_ref);
        sig_in = 1'b0;
        idle(SYNC + 1);
        check("R4", los, 1'b0);
        idle(3*WIN);

        // toggles spaced inside the two-window limit
        cur_req = "R6";
        for (int k = 0; k < 10; k++) begin
            sig_in = ~sig_in;
            idle(2*WIN - 1);
        end
        check("R6", los, 1'b0);

        // toggles spaced outside the limit
        cur_req = "R2";
        for (int k = 0; k < 6; k++) begin
            sig_in = ~sig_in;
            idle(2*WIN + 5);
            check("R2", los, 1'b1);
        end

        // irregular pattern
        cur_req = "R4";
        lfsr = 32'h1ACE;
        for (int k = 0; k < 600; k++) begin
            lfsr = (lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
            lfsr = lfsr & 32'hFFFF;
            if ((lfsr & 32'h3F) == 0) sig_in = ~sig_in;
            @(negedge clk_ref);
        end

        // reset mid-activity
        cur_req = "R1";
        sig_in = 1'b0;
        idle(SYNC + 2);
        rst_n = 1'b0;
        @(negedge clk_ref);
        check("R1", los, 1'b1);
        rst_n = 1'b1;
        idle(3*WIN);
        check("R1", los, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule